// File: doc/BRIEF.md
# Oversampling UART Receiver with Watermark Flow Control

This block is the receive half of an asynchronous serial port. It watches one serial line, finds start bits and recovers 8N1 characters: one start bit, eight data bits sent least significant bit first, and one stop bit. Each recovered byte goes into a small receive FIFO, together with a flag that says whether its stop bit was bad. A programmable divisor sets the oversampling tick. Each bit lasts either sixteen ticks or, when the high-speed select is set, eight ticks.

A loopback select makes the receiver listen to the local transmitter's serial output instead of the external line. Reception runs only while the port-level enable and the receive enable are both set. If either enable is cleared while a character is arriving, that character still finishes and is stored. The FIFO is read through a valid/ready stream. A byte leaves only in a cycle where `rd_valid` and `rd_ready` are both high. While `rd_valid` is high and `rd_ready` is low, the head byte and its flag stay unchanged. The receiver itself cannot be stalled: a byte that arrives while the FIFO is full is dropped, and this is reported by a one-cycle overrun pulse.

The request-to-send output tells the remote sender whether there is room. When watermark flow control is enabled, it is high while the FIFO level is below the programmed watermark and low at or above it. When flow control is disabled, it stays high.

Top module: `uart_rx_wm`

## Requirements
- R1: No byte enters the FIFO from a character that starts while `uart_en` or `rx_en` is low. `fifo_level` is unchanged after such a character.
- R2: If `rx_en` is cleared after a start bit has been accepted, that character is still completed and stored with its correct value.
- R3: One oversampling tick occurs every `baud_div`+1 clocks. A bit lasts 16 ticks when `hs_sel`=0 and 8 ticks when `hs_sel`=1. The start bit is followed by data bits 0 through 7, then a high stop bit. The byte appears on `rd_data` with bit 0 taken from the first data bit. Every data value is recovered in both oversampling modes.
- R4: A low level that is high again at the middle of the start bit (8 ticks after the falling edge in 16x mode, 4 ticks in 8x mode) is ignored and stores nothing. A later valid character is still received.
- R5: A character whose stop bit samples low is stored with `rd_ferr`=1. A character with a high stop bit is stored with `rd_ferr`=0.
- R6: With `loop_en`=1 the receiver decodes `tx_loop` and ignores `rx_pin`. With `loop_en`=0 it decodes `rx_pin`.
- R7: Bytes leave the FIFO in arrival order. `rd_valid` is high exactly when `fifo_level` is nonzero. While `rd_valid`=1 and `rd_ready`=0, `rd_data` and `rd_ferr` hold their values.
- R8: A character that completes while `fifo_full`=1 is discarded and leaves the FIFO contents unchanged. `overrun_o` is high for exactly one clock for each such character and is never high otherwise.
- R9: With `rts_en`=1, `rts_o` is 1 while `fifo_level` < `wm_level` and 0 while `fifo_level` >= `wm_level`. It returns to 1 as soon as reads bring the level below the watermark.
- R10: With `rts_en`=0, `rts_o` is 1 whatever the FIFO level.
- R11: A store and a read in the same clock leave `fifo_level` unchanged and keep the byte order.
- R12: `fifo_level` counts the stored bytes, from 0 to the FIFO depth. `fifo_full` is 1 exactly when the level equals the depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| uart_en | input | 1 | Port-level enable |
| rx_en | input | 1 | Receive enable |
| loop_en | input | 1 | 1: decode tx_loop instead of rx_pin |
| hs_sel | input | 1 | 1: 8 ticks per bit, 0: 16 ticks per bit |
| rts_en | input | 1 | Enable watermark-driven rts_o |
| baud_div | input | DIV_W | Tick period minus one, in clocks |
| wm_level | input | LVL_W | FIFO watermark level |
| rx_pin | input | 1 | External serial input, idle high |
| tx_loop | input | 1 | Local transmitter serial output |
| rd_valid | output | 1 | FIFO head holds a byte |
| rd_ready | input | 1 | Consumer accepts the head byte |
| rd_data | output | 8 | Head byte |
| rd_ferr | output | 1 | Head byte had a low stop bit |
| fifo_level | output | LVL_W | Number of stored bytes |
| fifo_full | output | 1 | FIFO holds DEPTH bytes |
| rts_o | output | 1 | High when the receiver has room |
| overrun_o | output | 1 | One-cycle pulse: a byte was dropped |

## Verification
The deserializer storing a byte and the consumer removing the head byte can fall in the same clock. The bench provokes this by placing one byte in the FIFO and then sending a second character. During that second character it raises `rd_ready` for a single clock, and it sweeps the position of that clock, one cycle at a time, across the whole window around the stop-bit sample. For every offset, the result must be a level of exactly one, with the newly received byte at the head.

// File: rtl/uart_rx_wm_pkg.sv
package uart_rx_wm_pkg;
  localparam int unsigned CHAR_BITS = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic                 ferr;
    logic [CHAR_BITS-1:0] data;
  } rx_char_t;
endpackage

// File: rtl/uart_rx_wm_tick.sv
module uart_rx_wm_tick #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (cnt_q >= div) begin
      cnt_q <= '0;
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      tick  <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_wm_front.sv
module uart_rx_wm_front #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic loop_en,
  input  logic rx_pin,
  input  logic tx_loop,
  output logic line
);
  logic                   raw;
  logic [SYNC_STAGES-1:0] sync_q;

  assign raw = loop_en ? tx_loop : rx_pin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
  end

  assign line = sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/uart_rx_wm_deser.sv
module uart_rx_wm_deser
  import uart_rx_wm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     active,
  input  logic     hs_sel,
  input  logic     line,
  output logic     push,
  output rx_char_t push_char
);
  localparam int unsigned CNT_W = 4;
  localparam int unsigned BIT_W = $clog2(CHAR_BITS);

  rx_state_e            state_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [BIT_W-1:0]     bit_q;
  logic [CHAR_BITS-1:0] shift_q;
  logic                 hs_q;
  logic                 armed_q;
  logic [CNT_W-1:0]     last_tick;
  logic [CNT_W-1:0]     mid_tick;

  assign last_tick = hs_q ? CNT_W'(7) : CNT_W'(15);
  assign mid_tick  = hs_q ? CNT_W'(3) : CNT_W'(7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      bit_q     <= '0;
      shift_q   <= '0;
      hs_q      <= 1'b0;
      armed_q   <= 1'b0;
      push      <= 1'b0;
      push_char <= '0;
    end else begin
      push <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (line) armed_q <= 1'b1;
          if (tick && active && armed_q && !line) begin
            state_q <= ST_START;
            cnt_q   <= '0;
            hs_q    <= hs_sel;
            armed_q <= 1'b0;
          end
        end
        ST_START: if (tick) begin
          if (cnt_q == mid_tick) begin
            cnt_q   <= '0;
            bit_q   <= '0;
            state_q <= line ? ST_IDLE : ST_DATA;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DATA: if (tick) begin
          if (cnt_q == last_tick) begin
            cnt_q   <= '0;
            shift_q <= {line, shift_q[CHAR_BITS-1:1]};
            if (bit_q == BIT_W'(CHAR_BITS - 1)) state_q <= ST_STOP;
            else                                bit_q   <= bit_q + 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_STOP: if (tick) begin
          if (cnt_q == last_tick) begin
            cnt_q          <= '0;
            push           <= 1'b1;
            push_char.data <= shift_q;
            push_char.ferr <= ~line;
            state_q        <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_wm_fifo.sv
module uart_rx_wm_fifo
  import uart_rx_wm_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  rx_char_t         push_char,
  input  logic             rd_ready,
  input  logic             rts_en,
  input  logic [LVL_W-1:0] wm_level,
  output logic             rd_valid,
  output rx_char_t         head,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             rts,
  output logic             overrun
);
  localparam int unsigned ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  rx_char_t          mem_q [DEPTH];
  logic [ADDR_W-1:0] wptr_q, rptr_q;
  logic              wr, rd;

  assign full     = (level == LVL_W'(DEPTH));
  assign rd_valid = (level != '0);
  assign wr       = push && !full;
  assign rd       = rd_valid && rd_ready;
  assign head     = mem_q[rptr_q];
  assign rts      = !rts_en || (level < wm_level);

  function automatic logic [ADDR_W-1:0] bump(input logic [ADDR_W-1:0] p);
    return (p == ADDR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level   <= '0;
      overrun <= 1'b0;
    end else begin
      overrun <= push && full;
      if (wr) wptr_q <= bump(wptr_q);
      if (rd) rptr_q <= bump(rptr_q);
      if (wr && !rd)      level <= level + 1'b1;
      else if (rd && !wr) level <= level - 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          mem_q[i] <= '0;
      else if (wr && wptr_q == ADDR_W'(i)) mem_q[i] <= push_char;
    end
  end
endmodule

// File: rtl/uart_rx_wm.sv
module uart_rx_wm
  import uart_rx_wm_pkg::*;
#(
  parameter int unsigned DIV_W = 16,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             uart_en,
  input  logic             rx_en,
  input  logic             loop_en,
  input  logic             hs_sel,
  input  logic             rts_en,
  input  logic [DIV_W-1:0] baud_div,
  input  logic [LVL_W-1:0] wm_level,
  input  logic             rx_pin,
  input  logic             tx_loop,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             rd_ferr,
  output logic [LVL_W-1:0] fifo_level,
  output logic             fifo_full,
  output logic             rts_o,
  output logic             overrun_o
);
  logic     tick, line, push;
  rx_char_t push_char, head;

  uart_rx_wm_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick)
  );

  uart_rx_wm_front #(.SYNC_STAGES(2)) u_front (
    .clk(clk), .rst_n(rst_n), .loop_en(loop_en),
    .rx_pin(rx_pin), .tx_loop(tx_loop), .line(line)
  );

  uart_rx_wm_deser u_deser (
    .clk(clk), .rst_n(rst_n), .tick(tick), .active(uart_en && rx_en),
    .hs_sel(hs_sel), .line(line), .push(push), .push_char(push_char)
  );

  uart_rx_wm_fifo #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_char(push_char),
    .rd_ready(rd_ready), .rts_en(rts_en), .wm_level(wm_level),
    .rd_valid(rd_valid), .head(head), .level(fifo_level),
    .full(fifo_full), .rts(rts_o), .overrun(overrun_o)
  );

  assign rd_data = head.data;
  assign rd_ferr = head.ferr;
endmodule

// File: rtl/uart_rx_wm_chk.sv
module uart_rx_wm_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rts_en,
  input logic [LVL_W-1:0] wm_level,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic [7:0]       rd_data,
  input logic             rd_ferr,
  input logic [LVL_W-1:0] fifo_level,
  input logic             fifo_full,
  input logic             rts_o,
  input logic             overrun_o
);
  // R12
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_level <= LVL_W'(DEPTH)) && (fifo_full == (fifo_level == LVL_W'(DEPTH))));

  // R7
  valid_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid == (fifo_level != '0));

  // R7
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data) && $stable(rd_ferr));

  // R8
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |-> $past(fifo_full));

  // R8
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full && !rd_ready |=> fifo_full);

  // R9
  rts_wm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rts_en && (fifo_level >= wm_level) |-> !rts_o);

  // R10
  rts_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rts_en |-> rts_o);

  // R11
  level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_level == $past(fifo_level)) ||
    (fifo_level == $past(fifo_level) + 1'b1) ||
    (fifo_level + 1'b1 == $past(fifo_level)));
endmodule

bind uart_rx_wm uart_rx_wm_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rts_en(rts_en), .wm_level(wm_level),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
  .rd_ferr(rd_ferr), .fifo_level(fifo_level), .fifo_full(fifo_full),
  .rts_o(rts_o), .overrun_o(overrun_o)
);

// File: tb/uart_rx_wm_bench.sv
module uart_rx_wm_bench;
  localparam int DIV_W = 4;
  localparam int DEPTH = 4;
  localparam int LVL_W = 3;
  localparam int DIV   = 1;

  logic clk = 0;
  logic rst_n = 0;
  logic uart_en = 0, rx_en = 0, loop_en = 0, hs_sel = 0, rts_en = 0;
  logic [DIV_W-1:0] baud_div = DIV_W'(DIV);
  logic [LVL_W-1:0] wm_level = 3'd2;
  logic rx_pin = 1, tx_loop = 1, rd_ready = 0;
  logic rd_valid, rd_ferr, fifo_full, rts_o, overrun_o;
  logic [7:0] rd_data;
  logic [LVL_W-1:0] fifo_level;

  int checks = 0, errors = 0, ovr_seen = 0;

  always #2 clk = ~clk;

  uart_rx_wm #(.DIV_W(DIV_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_uart_rx_wm (
    .clk(clk), .rst_n(rst_n), .uart_en(uart_en), .rx_en(rx_en),
    .loop_en(loop_en), .hs_sel(hs_sel), .rts_en(rts_en),
    .baud_div(baud_div), .wm_level(wm_level), .rx_pin(rx_pin),
    .tx_loop(tx_loop), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_ferr(rd_ferr), .fifo_level(fifo_level),
    .fifo_full(fifo_full), .rts_o(rts_o), .overrun_o(overrun_o)
  );

  always @(negedge clk) if (rst_n && overrun_o) ovr_seen++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bitclk();
    return (DIV + 1) * (hs_sel ? 8 : 16);
  endfunction

  task automatic drive(input bit on_loop, input bit v);
    if (on_loop) tx_loop = v; else rx_pin = v;
  endtask

  task automatic send(input [7:0] b, input bit stopv, input bit on_loop);
    int bc = bitclk();
    @(negedge clk);
    drive(on_loop, 1'b0);
    repeat (bc) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      drive(on_loop, b[i]);
      repeat (bc) @(negedge clk);
    end
    drive(on_loop, stopv);
    repeat (bc) @(negedge clk);
    drive(on_loop, 1'b1);
    repeat (bc) @(negedge clk);
  endtask

  task automatic pop();
    @(negedge clk);
    rd_ready = 1;
    @(negedge clk);
    rd_ready = 0;
  endtask

  task automatic expect_head(input [7:0] b, input bit fe, input string req);
    chk(rd_valid && rd_data == b, req, rd_data, b);
    chk(rd_ferr == fe, req, rd_ferr, fe);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int o;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R7 R10 R12: reset state
    chk(!rd_valid && fifo_level == 0 && !fifo_full, "R12 reset", fifo_level, 0);
    chk(rts_o == 1 && overrun_o == 0, "R10 reset", rts_o, 1);
    uart_en = 1;
    rx_en = 1;

    // R3: every byte in 8x mode
    hs_sel = 1;
    for (int b = 0; b < 256; b++) begin
      send(8'(b), 1, 0);
      chk(fifo_level == 1, "R3 hs level", fifo_level, 1);
      expect_head(8'(b), 0, "R3 hs data");
      pop();
    end
    // R3: spread of bytes in 16x mode
    hs_sel = 0;
    for (int i = 0; i < 64; i++) begin
      send(8'(i * 4 + (i % 4)), 1, 0);
      expect_head(8'(i * 4 + (i % 4)), 0, "R3 16x data");
      pop();
    end

    // R6: loopback source
    loop_en = 1;
    send(8'hA5, 1, 1);
    expect_head(8'hA5, 0, "R6 loop data");
    pop();
    send(8'h3C, 1, 0);
    chk(fifo_level == 0, "R6 pin ignored", fifo_level, 0);
    loop_en = 0;
    send(8'h3D, 1, 1);
    chk(fifo_level == 0, "R6 loop ignored", fifo_level, 0);

    // R4: short low pulse is not a start bit
    @(negedge clk);
    rx_pin = 0;
    repeat ((DIV + 1) * 4) @(negedge clk);
    rx_pin = 1;
    repeat (12 * bitclk()) @(negedge clk);
    chk(fifo_level == 0, "R4 glitch", fifo_level, 0);
    send(8'h5A, 1, 0);
    expect_head(8'h5A, 0, "R4 recovery");
    pop();

    // R5: framing error
    send(8'hC3, 0, 0);
    chk(fifo_level == 1, "R5 stored", fifo_level, 1);
    expect_head(8'hC3, 1, "R5 ferr");
    pop();
    send(8'h81, 1, 0);
    expect_head(8'h81, 0, "R5 good stop");
    pop();

    // R1: enables gate reception
    rx_en = 0;
    send(8'h11, 1, 0);
    chk(fifo_level == 0, "R1 rx_en low", fifo_level, 0);
    rx_en = 1;
    uart_en = 0;
    send(8'h22, 1, 0);
    chk(fifo_level == 0, "R1 uart_en low", fifo_level, 0);
    uart_en = 1;

    // R2: disable mid-character
    fork
      send(8'h6E, 1, 0);
      begin repeat (3 * bitclk()) @(negedge clk); rx_en = 0; end
    join
    chk(fifo_level == 1, "R2 completed", fifo_level, 1);
    expect_head(8'h6E, 0, "R2 data");
    send(8'h77, 1, 0);
    chk(fifo_level == 1, "R2 stays off", fifo_level, 1);
    pop();
    rx_en = 1;

    // R9 R10 R8 R7: fill, watermark, overflow, drain
    hs_sel = 1;
    rts_en = 1;
    @(negedge clk);
    chk(rts_o == 1, "R9 level0", rts_o, 1);
    for (int k = 0; k < 4; k++) begin
      send(8'(8'h10 + k), 1, 0);
      chk(fifo_level == 3'(k + 1), "R12 fill", fifo_level, k + 1);
      chk(rts_o == (k + 1 < 2), "R9 fill rts", rts_o, (k + 1 < 2));
    end
    chk(fifo_full == 1, "R12 full", fifo_full, 1);
    rts_en = 0;
    @(negedge clk);
    chk(rts_o == 1, "R10 full", rts_o, 1);
    rts_en = 1;
    o = ovr_seen;
    send(8'hEE, 1, 0);
    chk(ovr_seen == o + 1, "R8 pulse", ovr_seen - o, 1);
    chk(fifo_level == 4, "R8 level", fifo_level, 4);
    repeat (5) @(negedge clk);
    expect_head(8'h10, 0, "R7 hold");
    for (int k = 0; k < 4; k++) begin
      expect_head(8'(8'h10 + k), 0, "R7 order");
      pop();
      chk(fifo_level == 3'(3 - k), "R12 drain", fifo_level, 3 - k);
      chk(rts_o == (3 - k < 2), "R9 drain rts", rts_o, (3 - k < 2));
    end
    chk(ovr_seen == o + 1, "R8 only once", ovr_seen - o, 1);

    // R11: read swept across the store cycle
    for (int d = 148; d <= 168; d++) begin
      send(8'h40, 1, 0);
      fork
        send(8'(8'h80 + d), 1, 0);
        begin
          repeat (d) @(negedge clk);
          rd_ready = 1;
          @(negedge clk);
          rd_ready = 0;
        end
      join
      chk(fifo_level == 1, "R11 level", fifo_level, 1);
      expect_head(8'(8'h80 + d), 0, "R11 order");
      pop();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule